// File: doc/BRIEF.md
# Half-Integer Clock Divider Branch

This block is one branch of a clock tree. It has three stages in series. The first stage is a source selector that picks one of two input clocks. The second is an enable gate. The third divides the clock by a half-integer ratio. With field value v the ratio is (2·v+3)/2, so the output runs at 1/1.5, 1/2.5, 1/3.5 and so on of the selected source. To get half-cycle resolution, the divider keeps one flop on the rising edge and one on the falling edge of the source. The output is the XOR of the two flops, so only one input of that XOR changes at any edge.

Software programs the branch through two 16-bit registers. The main register holds the divider field and the source-select bit. A second register can hold the gate-enable bit, or that bit can sit in the main register. A write carries a 32-bit word whose upper half is a per-bit write enable for the lower half, so no read-modify-write is needed. Reads return the stored 16 bits with zeros above them. Parameters set the bit positions and field width. Other parameters can leave out any of the three stages.

Top module: `half_div_branch`

## Requirements
- R1: With divider value v, each output period lasts 2·v+3 half-periods of the selected source. The output is high for v+2 half-periods and low for v+1.
- R2: v is the unsigned DIV_W-bit field at bit DIV_LSB of register 0 (wr_sel/rd_sel = 0). v=0 gives the smallest ratio, 1.5. The all-ones value gives the largest ratio.
- R3: A write changes low-half bit i of the addressed register only when bit i+16 of wr_data is 1. Every other bit keeps its value.
- R4: rd_data returns the addressed register's 16 stored bits in bits 15:0. Bits 31:16 read as zero.
- R5: Bit MUX_BIT of register 0 selects the source: 0 selects src_clk0 and 1 selects src_clk1.
- R6: The gate enable is bit GATE_BIT of register 1, or of register 0 when GATE_IN_CTRL=1. It is sampled on the falling source edge. While it is 0, div_out stays low. When it turns on, the first high phase has full length.
- R7: A new divider value is loaded only when the internal frame of two output periods wraps. An update that lands early in a frame leaves both periods of that frame at the old timing.
- R8: rst, sampled synchronously, clears both registers. After reset the branch selects src_clk0 with the gate off and v=0, and div_out is low.
- R9: With HAS_DIV=0, div_out equals the gated source clock. With HAS_MUX=0, src_clk0 is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk0 | input | 1 | Source clock 0 |
| src_clk1 | input | 1 | Source clock 1 |
| reg_clk | input | 1 | Register port clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 main register, 1 gate register |
| wr_data | input | 32 | Write word: bits 31:16 mask, bits 15:0 data |
| rd_sel | input | 1 | Read target: 0 main register, 1 gate register |
| rd_data | output | 32 | Read word, upper half zero |
| div_out | output | 1 | Divided, gated branch clock |

## Verification
Two events can fall in the same cycle: a write to the divider field, and the rising output edge that opens a two-period frame. The bench waits for an output rise that coincides with a rising source edge, which marks the start of a frame. It then issues the write concurrently and samples the output once per source half-period. The sampled pattern must show two full periods at the old value and then the new timing. The same half-period sampling judges the gate-on transition: the first high run must have full length.

// File: rtl/half_div_branch.sv
module half_div_branch #(
  parameter int DIV_W        = 5,
  parameter int DIV_LSB      = 0,
  parameter int MUX_BIT      = 8,
  parameter int GATE_BIT     = 0,
  parameter int GATE_IN_CTRL = 0,
  parameter int HAS_MUX      = 1,
  parameter int HAS_GATE     = 1,
  parameter int HAS_DIV      = 1
) (
  input  logic        src_clk0,
  input  logic        src_clk1,
  input  logic        reg_clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        div_out
);
  localparam int CW = DIV_W + 2;
  localparam int HW = CW + 1;

  logic [15:0] ctrl_q, gctl_q;
  logic [15:0] wmask, wval;
  assign wmask = wr_data[31:16];
  assign wval  = wr_data[15:0] & wmask;

  always_ff @(posedge reg_clk) begin
    if (rst) begin
      ctrl_q <= '0;
      gctl_q <= '0;
    end else if (wr_en) begin
      if (!wr_sel) ctrl_q <= (ctrl_q & ~wmask) | wval;
      else         gctl_q <= (gctl_q & ~wmask) | wval;
    end
  end

  assign rd_data = {16'h0000, rd_sel ? gctl_q : ctrl_q};

  logic [DIV_W-1:0] v_field;
  assign v_field = ctrl_q[DIV_LSB +: DIV_W];

  logic sclk, gate_en, gate_q;

  if (HAS_MUX != 0) begin : g_mux
    assign sclk = ctrl_q[MUX_BIT] ? src_clk1 : src_clk0;
  end else begin : g_nomux
    assign sclk = src_clk0;
  end

  if (HAS_GATE == 0) begin : g_nogate
    assign gate_en = 1'b1;
  end else if (GATE_IN_CTRL != 0) begin : g_gate_ctrl
    assign gate_en = ctrl_q[GATE_BIT];
  end else begin : g_gate_sep
    assign gate_en = gctl_q[GATE_BIT];
  end

  always_ff @(negedge sclk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_en;
  end

  logic             run_q;
  logic [CW-1:0]    cnt_q;
  logic [DIV_W-1:0] v_cur;
  logic             tp_q, tn_q;

  function automatic logic hi_at(input logic [HW-1:0] h, input logic [DIV_W-1:0] v);
    logic [HW-1:0] per;
    logic [HW-1:0] hh;
    per = HW'({v, 1'b1}) + HW'(2);
    hh  = (h >= per) ? h - per : h;
    return hh < (HW'(v) + HW'(2));
  endfunction

  if (HAS_DIV != 0) begin : g_div
    logic [CW-1:0] lim, c_nxt;
    assign lim   = CW'({v_cur, 1'b0}) + CW'(2);
    assign c_nxt = cnt_q + CW'(1);

    always_ff @(posedge sclk) begin
      if (rst) begin
        run_q <= 1'b0;
        cnt_q <= '0;
        v_cur <= '0;
        tp_q  <= 1'b0;
      end else if (!gate_q) begin
        run_q <= 1'b0;
        cnt_q <= '0;
        tp_q  <= tn_q;
      end else if (!run_q || cnt_q == lim) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        v_cur <= v_field;
        tp_q  <= ~tn_q;
      end else begin
        cnt_q <= c_nxt;
        tp_q  <= hi_at({c_nxt, 1'b0}, v_cur) ^ tn_q;
      end
    end

    always_ff @(negedge sclk) begin
      if (rst)                   tn_q <= 1'b0;
      else if (gate_en && run_q) tn_q <= hi_at({cnt_q, 1'b1}, v_cur) ^ tp_q;
      else                       tn_q <= tp_q;
    end

    assign div_out = tp_q ^ tn_q;
  end else begin : g_nodiv
    assign run_q   = 1'b0;
    assign cnt_q   = '0;
    assign v_cur   = '0;
    assign tp_q    = 1'b0;
    assign tn_q    = 1'b0;
    assign div_out = sclk & gate_q;
  end
endmodule

// File: rtl/half_div_branch_chk.sv
module half_div_branch_chk #(
  parameter int DIV_W = 5
) (
  input logic             reg_clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [31:0]      wr_data,
  input logic [15:0]      ctrl_q,
  input logic             sclk,
  input logic             gate_q,
  input logic             run_q,
  input logic [DIV_W+1:0] cnt_q,
  input logic [DIV_W-1:0] v_cur,
  input logic             div_out
);
  logic rst_seen;
  always_ff @(posedge reg_clk) rst_seen <= rst;

  AST_MASK_HOLD: assert property (@(posedge reg_clk) disable iff (rst)
    (wr_en && !wr_sel) |=> (((ctrl_q ^ $past(ctrl_q)) & ~$past(wr_data[31:16])) == 16'h0)); // R3

  AST_RESET_CLEAR: assert property (@(posedge reg_clk) disable iff (rst)
    rst_seen |-> (ctrl_q == 16'h0)); // R8

  AST_CNT_BOUND: assert property (@(posedge sclk) disable iff (rst)
    ({1'b0, cnt_q} <= ({2'b00, v_cur, 1'b0} + (DIV_W+3)'(2)))); // R1

  AST_LOAD_AT_WRAP: assert property (@(posedge sclk) disable iff (rst)
    !$stable(v_cur) |-> (cnt_q == '0)); // R7

  AST_GATED_LOW: assert property (@(posedge sclk) disable iff (rst)
    (!gate_q && !run_q) |-> !div_out); // R6
endmodule

bind half_div_branch half_div_branch_chk #(.DIV_W(DIV_W)) u_chk (
  .reg_clk(reg_clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ctrl_q(ctrl_q), .sclk(sclk), .gate_q(gate_q), .run_q(run_q), .cnt_q(cnt_q),
  .v_cur(v_cur), .div_out(div_out)
);

// File: tb/half_div_branch_test.sv
`timescale 1ns/1ps
module half_div_branch_test;
  logic clk = 1'b0, src1 = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_en_nd = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_nd;
  logic div_out, out_nd;
  int total = 0, bad = 0;
  bit smp [0:79];
  bit refc [0:79];

  always #10 clk = ~clk;
  always #16 src1 = ~src1;

  half_div_branch #(.DIV_W(3), .DIV_LSB(2), .MUX_BIT(9), .GATE_BIT(5), .GATE_IN_CTRL(0)) uut (
    .src_clk0(clk), .src_clk1(src1), .reg_clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .div_out(div_out));

  half_div_branch #(.DIV_W(3), .HAS_DIV(0), .HAS_MUX(0), .GATE_IN_CTRL(1), .GATE_BIT(0)) uut_nd (
    .src_clk0(clk), .src_clk1(src1), .reg_clk(clk), .rst(rst), .wr_en(wr_en_nd), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data_nd), .div_out(out_nd));

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] d, input bit nd);
    @(negedge clk);
    wr_sel = sel; wr_data = d;
    if (nd) wr_en_nd = 1'b1; else wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_en_nd = 1'b0;
  endtask

  task automatic rd_chk(input bit sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_sel = sel;
    #1;
    chk(rd_data == exp, tag, int'(rd_data), int'(exp));
  endtask

  task automatic grab(input bit use1, input bit nd, input int n);
    for (int i = 0; i < n; i++) begin
      if (use1) begin @(posedge src1 or negedge src1); #8; end
      else begin @(posedge clk or negedge clk); #5; end
      smp[i]  = nd ? out_nd : div_out;
      refc[i] = use1 ? src1 : clk;
    end
  endtask

  task automatic runs(input int n, output int hi, output int lo);
    int i;
    i = 1; hi = 0; lo = 0;
    while (i < n && !(smp[i-1] == 1'b0 && smp[i] == 1'b1)) i++;
    while (i < n && smp[i]) begin hi++; i++; end
    while (i < n && !smp[i]) begin lo++; i++; end
  endtask

  task automatic sweep(input bit use1, input string tag);
    for (int v = 0; v < 8; v++) begin
      logic [2:0] vv;
      int hi, lo;
      vv = 3'(v);
      wr(1'b0, {16'h001C, 11'd0, vv, 2'b00}, 1'b0);
      grab(use1, 1'b0, 40);
      grab(use1, 1'b0, 64);
      runs(64, hi, lo);
      chk(hi == v + 2 && lo == v + 1, (v == 0 || v == 7) ? {tag, " R2 ratio extreme"} : tag,
          hi * 100 + lo, (v + 2) * 100 + v + 1);
    end
  endtask

  initial begin
    #3_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int hi, lo, ones, miss;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    rd_chk(1'b0, 32'h0, "R8 ctrl after reset");
    rd_chk(1'b1, 32'h0, "R8 gate reg after reset");
    grab(1'b0, 1'b0, 16);
    ones = 0;
    for (int i = 0; i < 16; i++) ones += int'(smp[i]);
    chk(ones == 0, "R8 output low after reset", ones, 0);

    // R3 / R4 masked writes and readback
    wr(1'b0, 32'hFFFF_A5A5, 1'b0);
    rd_chk(1'b0, 32'h0000_A5A5, "R4 full-mask write readback");
    wr(1'b0, 32'h00F0_0F0F, 1'b0);
    rd_chk(1'b0, 32'h0000_A505, "R3 partial mask");
    wr(1'b0, 32'h0000_FFFF, 1'b0);
    rd_chk(1'b0, 32'h0000_A505, "R3 zero mask ignored");
    wr(1'b1, 32'hFFFF_1234, 1'b0);
    rd_chk(1'b1, 32'h0000_1234, "R4 gate reg readback upper zero");
    rd_chk(1'b0, 32'h0000_A505, "R3 other register untouched");
    wr(1'b0, 32'hFFFF_0000, 1'b0);
    wr(1'b1, 32'hFFFF_0000, 1'b0);
    rd_chk(1'b0, 32'h0, "R3 clear ctrl");

    // R1 / R2 sweep on source 0, then R5 on source 1
    wr(1'b1, 32'h0020_0020, 1'b0);
    sweep(1'b0, "R1 src0 half-period pattern");
    wr(1'b0, 32'h0200_0200, 1'b0);
    sweep(1'b1, "R5 src1 half-period pattern");
    wr(1'b0, 32'h0200_0000, 1'b0);

    // R6 gate off then on
    wr(1'b1, 32'h0020_0000, 1'b0);
    grab(1'b0, 1'b0, 8);
    grab(1'b0, 1'b0, 20);
    ones = 0;
    for (int i = 0; i < 20; i++) ones += int'(smp[i]);
    chk(ones == 0, "R6 gate off holds low", ones, 0);
    wr(1'b0, 32'h001C_0008, 1'b0);
    fork
      wr(1'b1, 32'h0020_0020, 1'b0);
      grab(1'b0, 1'b0, 40);
    join
    runs(40, hi, lo);
    chk(!smp[0] && hi == 4 && lo == 3, "R6 first high phase full length", hi * 100 + lo, 403);

    // R7 update lands at frame start
    wr(1'b0, 32'h001C_001C, 1'b0);
    grab(1'b0, 1'b0, 40);
    begin
      bit found;
      found = 1'b0;
      while (!found) begin
        @(posedge div_out);
        #1;
        if (clk) found = 1'b1;
      end
    end
    fork
      wr(1'b0, 32'h001C_0000, 1'b0);
      grab(1'b0, 1'b0, 46);
    join
    miss = 0;
    for (int k = 0; k < 46; k++) begin
      int h;
      bit e;
      h = k + 1;
      e = (h < 34) ? ((h % 17) < 9) : (((h - 34) % 3) < 2);
      if (smp[k] != e) miss++;
    end
    chk(miss == 0, "R7 frame keeps old timing", miss, 0);

    // R9 stage omission: no divider, no mux
    wr(1'b0, 32'h0001_0001, 1'b1);
    grab(1'b0, 1'b1, 4);
    grab(1'b0, 1'b1, 20);
    miss = 0;
    for (int i = 0; i < 20; i++) if (smp[i] != refc[i]) miss++;
    chk(miss == 0, "R9 no-divider output follows gated source", miss, 0);
    wr(1'b0, 32'h0001_0000, 1'b1);
    grab(1'b0, 1'b1, 4);
    grab(1'b0, 1'b1, 20);
    ones = 0;
    for (int i = 0; i < 20; i++) ones += int'(smp[i]);
    chk(ones == 0, "R9 no-divider gate off low", ones, 0);

    // R8 reset while running
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_chk(1'b0, 32'h0, "R8 ctrl cleared by reset");
    rd_chk(1'b1, 32'h0, "R8 gate reg cleared by reset");
    grab(1'b0, 1'b0, 12);
    ones = 0;
    for (int i = 0; i < 12; i++) ones += int'(smp[i]);
    chk(ones == 0, "R8 output low after mid-run reset", ones, 0);

    summary();
    $finish;
  end
endmodule